// File: doc/BRIEF.md
# Memory Configuration Register Unit

This block holds the memory-management state of a small 8-bit system and turns it into bank and region controls. The CPU reaches it through a narrow register port: a register select, a write strobe, write data and combinational read data. The live configuration word selects the processor RAM bank and the source of the top 16 kB of the address space. A separate RAM configuration word selects the video RAM bank, a RAM block field and a shared "common" RAM window.

Four alternate configuration words can be staged in advance. A single write to one of four load offsets copies the matching staged word into the live register. This lets software switch the whole memory map with one store, without a read-modify-write. The block also watches the current CPU address and reports the effective bank. Inside an enabled common window that bank is forced to 0. It also reports whether the top region is currently served by ROM.

Top module: `mcr_top`

## Requirements
- R1: After reset every register reads 0, the effective bank is 0, the top-region source is system ROM (code 00) and no address is reported as common.
- R2: Offset 0 is the live configuration register; it reads back what was written, and its bits 7–6 give the effective bank for addresses outside the common window.
- R3: Offsets 1, 2, 3 and 4 are staged words A, B, C and D; each reads back what was written, and writing them leaves the live configuration unchanged.
- R4: A write of any data to offset 5, 6, 7 or 8 copies staged word A, B, C or D respectively into the live configuration on that clock edge; the written data is ignored and the staged words keep their values.
- R5: Reading offset 5, 6, 7 or 8 returns staged word A, B, C or D respectively.
- R6: Live configuration bits 5–4 drive `top_src` (00 system ROM, 01 internal function ROM, 10 external function ROM, 11 RAM); `rom_en` is 1 exactly when the address lies in 0xC000–0xFFFF and the code is not 11.
- R7: Offset 9 is the RAM configuration register; it reads back what was written, bits 7–6 drive `vid_bank` and bits 5–4 drive `ram_block`.
- R8: RAM configuration bits 3–2 give the common window size (00 none, 01 1 kB, 10 4 kB, 11 16 kB); bit 0 places a window at the bottom of the address space and bit 1 one at the top; an address inside an enabled window raises `in_common` and forces `bank_sel` to 0.
- R9: Offsets 10 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` |
| cpu_addr | input | 16 | Current CPU address |
| bank_sel | output | 2 | Effective RAM bank for `cpu_addr` |
| top_src | output | 2 | Top-region source code |
| rom_en | output | 1 | Top region served by ROM at `cpu_addr` |
| vid_bank | output | 2 | Video RAM bank |
| ram_block | output | 2 | RAM block field |
| in_common | output | 1 | `cpu_addr` falls in the common window |

## Verification
The hardest case is the edge of the common window. A window has three sizes and two placements, and both placements can be active at once. The bank override only shows when the live bank is nonzero, so the check has to use an address right at the window boundary. The bench first loads a nonzero bank through a staged word and a load strobe. It then probes the last address inside and the first address outside each window, for several size and placement combinations, including both windows enabled together.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [1:0] {
    TOP_SYS_ROM = 2'b00,
    TOP_INT_ROM = 2'b01,
    TOP_EXT_ROM = 2'b10,
    TOP_RAM     = 2'b11
  } top_src_e;

  typedef struct packed {
    logic [1:0] bank;
    logic [1:0] top;
    logic [3:0] spare;
  } cfg_t;

  typedef struct packed {
    logic [1:0] vid;
    logic [1:0] blk;
    logic [1:0] csize;
    logic       place_top;
    logic       place_bot;
  } ramcfg_t;
endpackage

// File: rtl/mcr_rst_sync.sv
module mcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
  parameter int SEL_W  = 4,
  parameter int DATA_W = 8,
  parameter int N_PRE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] ramcfg_o
);
  localparam int CFG_OFS   = 0;
  localparam int PRE_BASE  = 1;
  localparam int LOAD_BASE = PRE_BASE + N_PRE;
  localparam int RAM_OFS   = LOAD_BASE + N_PRE;

  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [DATA_W-1:0] ram_q, ram_d;
  logic [DATA_W-1:0] pre_q [N_PRE];
  logic [DATA_W-1:0] pre_d [N_PRE];
  logic              cfg_en, ram_en;
  logic [N_PRE-1:0]  pre_en;

  // next-state: live config from direct write or from a load strobe
  always_comb begin
    cfg_en = 1'b0;
    cfg_d  = cfg_q;
    if (reg_wr && reg_sel == SEL_W'(CFG_OFS)) begin
      cfg_en = 1'b1;
      cfg_d  = reg_wdata;
    end
    for (int i = 0; i < N_PRE; i++) begin
      if (reg_wr && reg_sel == SEL_W'(LOAD_BASE + i)) begin
        cfg_en = 1'b1;
        cfg_d  = pre_q[i];
      end
    end
    ram_en = reg_wr && reg_sel == SEL_W'(RAM_OFS);
    ram_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ram_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (ram_en) ram_q <= ram_d;
    end
  end

  for (genvar g = 0; g < N_PRE; g++) begin : g_pre
    always_comb begin
      pre_en[g] = reg_wr && reg_sel == SEL_W'(PRE_BASE + g);
      pre_d[g]  = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q[g] <= '0;
      else if (pre_en[g]) pre_q[g] <= pre_d[g];
    end

    a_r3_pre_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_W'(PRE_BASE + g)) |=>
        (pre_q[g] == $past(reg_wdata) && cfg_q == $past(cfg_q)));

    a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_W'(LOAD_BASE + g)) |=>
        (cfg_q == $past(pre_q[g]) && pre_q[g] == $past(pre_q[g])));
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_W'(CFG_OFS)) reg_rdata = cfg_q;
    if (reg_sel == SEL_W'(RAM_OFS)) reg_rdata = ram_q;
    for (int i = 0; i < N_PRE; i++) begin
      if (reg_sel == SEL_W'(PRE_BASE + i))  reg_rdata = pre_q[i];
      if (reg_sel == SEL_W'(LOAD_BASE + i)) reg_rdata = pre_q[i];
    end
  end

  assign cfg_o    = cfg_q;
  assign ramcfg_o = ram_q;

  a_r9_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_sel) > RAM_OFS) |=> ($stable(cfg_q) && $stable(ram_q)));

  a_r7_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_W'(RAM_OFS)) |=> ram_q == $past(reg_wdata));
endmodule

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  cfg_t              cfg,
  input  ramcfg_t           ramcfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        bank_sel,
  output top_src_e          top_src,
  output logic              rom_en,
  output logic              in_common
);
  // window of code c spans 2^(ADDR_W-8+2c) bytes
  localparam int SHIFT_BASE = ADDR_W - 8;

  int   shift;
  logic bot_hit, top_hit, top_region;

  always_comb begin
    shift     = SHIFT_BASE + 2 * int'(ramcfg.csize);
    bot_hit   = ((addr >> shift) == '0);
    top_hit   = ((~addr >> shift) == '0);
    in_common = (ramcfg.csize != 2'b00) &&
                ((ramcfg.place_bot && bot_hit) || (ramcfg.place_top && top_hit));
    bank_sel  = in_common ? 2'b00 : cfg.bank;
    top_src   = top_src_e'(cfg.top);
    top_region = (addr[ADDR_W-1 -: 2] == 2'b11);
    rom_en    = top_region && (top_src != TOP_RAM);
  end
endmodule

// File: rtl/mcr_top.sv
module mcr_top
  import mcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 4,
  parameter int N_PRE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [1:0]        bank_sel,
  output logic [1:0]        top_src,
  output logic              rom_en,
  output logic [1:0]        vid_bank,
  output logic [1:0]        ram_block,
  output logic              in_common
);
  logic     rst_n_sync;
  logic [7:0] cfg_w, ram_w;
  cfg_t     cfg_s;
  ramcfg_t  ram_s;
  top_src_e top_e;

  mcr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mcr_regfile #(.SEL_W(SEL_W), .DATA_W(8), .N_PRE(N_PRE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg_o     (cfg_w),
    .ramcfg_o  (ram_w)
  );

  assign cfg_s = cfg_t'(cfg_w);
  assign ram_s = ramcfg_t'(ram_w);

  mcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cfg       (cfg_s),
    .ramcfg    (ram_s),
    .addr      (cpu_addr),
    .bank_sel  (bank_sel),
    .top_src   (top_e),
    .rom_en    (rom_en),
    .in_common (in_common)
  );

  assign top_src   = top_e;
  assign vid_bank  = ram_s.vid;
  assign ram_block = ram_s.blk;

  a_r8_common_bank0: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_common |-> bank_sel == 2'b00);

  a_r8_no_window: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ram_w[3:2] == 2'b00) |-> !in_common);

  a_r6_rom_region: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rom_en |-> (cpu_addr[ADDR_W-1 -: 2] == 2'b11 && top_src != 2'b11));

  a_r2_bank_outside: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_common |-> bank_sel == cfg_w[7:6]);
endmodule

// File: tb/mcr_top_tb_top.sv
module mcr_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  bank_sel, top_src, vid_bank, ram_block;
  logic        rom_en, in_common;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcr_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .bank_sel(bank_sel), .top_src(top_src), .rom_en(rom_en),
    .vid_bank(vid_bank), .ram_block(ram_block), .in_common(in_common)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    reg_sel = 4'(sel); reg_wdata = 8'(data); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int sel, input int exp);
    reg_sel = 4'(sel);
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic addr_chk(input string req, input int a, input int bank, input int com);
    cpu_addr = 16'(a);
    #1;
    chk(req, int'(bank_sel), bank);
    chk(req, int'(in_common), com);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 16; s++) rd_chk("R1 reg", s, 0);
    addr_chk("R1 addr", 16'h8000, 0, 0);
    chk("R1 top_src", int'(top_src), 0);
  endtask

  task automatic t_cfg;
    wr(0, 8'hC5);
    rd_chk("R2 readback", 0, 8'hC5);
    addr_chk("R2 bank", 16'h4000, 3, 0);
  endtask

  task automatic t_pre;
    wr(1, 8'h80); wr(2, 8'h50); wr(3, 8'hA0); wr(4, 8'h7E);
    rd_chk("R3 A", 1, 8'h80); rd_chk("R3 B", 2, 8'h50);
    rd_chk("R3 C", 3, 8'hA0); rd_chk("R3 D", 4, 8'h7E);
    rd_chk("R3 live kept", 0, 8'hC5);
    rd_chk("R5 A", 5, 8'h80); rd_chk("R5 B", 6, 8'h50);
    rd_chk("R5 C", 7, 8'hA0); rd_chk("R5 D", 8, 8'h7E);
  endtask

  task automatic t_load;
    wr(6, 8'hFF);
    rd_chk("R4 load B", 0, 8'h50);
    rd_chk("R4 B kept", 2, 8'h50);
    wr(8, 8'h00);
    rd_chk("R4 load D", 0, 8'h7E);
    wr(5, 8'h33);
    rd_chk("R4 load A", 0, 8'h80);
    rd_chk("R4 A kept", 1, 8'h80);
  endtask

  task automatic t_top;
    for (int c = 0; c < 4; c++) begin
      wr(0, 8'h40 | (c << 4));
      cpu_addr = 16'hC000; #1;
      chk("R6 top_src", int'(top_src), c);
      chk("R6 rom_en top", int'(rom_en), (c != 3) ? 1 : 0);
      cpu_addr = 16'hBFFF; #1;
      chk("R6 rom_en below", int'(rom_en), 0);
    end
  endtask

  task automatic t_ramcfg;
    wr(9, 8'hE0);
    rd_chk("R7 readback", 9, 8'hE0);
    chk("R7 vid_bank", int'(vid_bank), 3);
    chk("R7 ram_block", int'(ram_block), 2);
  endtask

  task automatic t_common;
    wr(5, 0);  // live = 0x80, bank 2
    wr(9, 8'h05); // 1 kB bottom
    addr_chk("R8 1k in", 16'h03FF, 0, 1);
    addr_chk("R8 1k out", 16'h0400, 2, 0);
    addr_chk("R8 1k top off", 16'hFFFF, 2, 0);
    wr(9, 8'h0E); // 16 kB top
    addr_chk("R8 16k in", 16'hC000, 0, 1);
    addr_chk("R8 16k out", 16'hBFFF, 2, 0);
    wr(9, 8'h0B); // 4 kB both
    addr_chk("R8 4k bot", 16'h0FFF, 0, 1);
    addr_chk("R8 4k mid", 16'h1000, 2, 0);
    addr_chk("R8 4k top", 16'hF000, 0, 1);
    addr_chk("R8 4k top out", 16'hEFFF, 2, 0);
    wr(9, 8'h03); // size none
    addr_chk("R8 size none", 16'h0000, 2, 0);
  endtask

  task automatic t_unused;
    for (int s = 10; s < 16; s++) wr(s, 8'hFF);
    for (int s = 10; s < 16; s++) rd_chk("R9 read", s, 0);
    rd_chk("R9 live", 0, 8'h80);
    rd_chk("R9 ramcfg", 9, 8'h03);
    rd_chk("R9 pre A", 1, 8'h80);
    rd_chk("R9 pre D", 4, 8'h7E);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset; t_cfg; t_pre; t_load; t_top; t_ramcfg; t_common; t_unused;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule